// File: doc/BRIEF.md
# Address match breakpoint unit

This block watches a CPU address bus with a single comparator and asks the CPU to stop and enter background (debug) mode when a chosen address is reached. Software or a debug host loads a 16-bit match address, an enable bit and a mode bit through a small write-only register port. Every bus cycle flagged valid is compared against the whole match address.

In forced mode, any access to the match address arms a pending flag. The request to enter background mode goes out after the next instruction-boundary strobe, so the address may hold data or code. In tagged mode, the block marks an opcode when it is fetched from the match address, and the CPU carries that mark through its instruction queue. The request is raised only when the marked opcode reaches execution, in place of that opcode. A marked opcode that is flushed from the queue never causes a stop, so tagged mode is useful only at opcode addresses.

Top module: `addr_bkpt`

## Requirements
- R1: After reset the match address is 0x0000, the unit is disabled, the mode bit selects tagged mode, and both fetchTag and bkptReq are low.
- R2: A write with regAddr = 0 loads regWrData[15:0] as the match address. A write with regAddr = 1 loads the enable bit from regWrData[0] and the mode bit from regWrData[1]. Writes to regAddr = 2 or 3 change nothing.
- R3: While the enable bit is 0, fetchTag stays low and bkptReq never rises, whatever the mode, match address or bus activity.
- R4: When the unit is enabled and the mode bit is 0 (tagged), fetchTag is high in the same cycle as a valid opcode fetch (busValid = 1, busFetch = 1) whose address equals the match address. fetchTag is low for data accesses (busFetch = 0).
- R5: When the unit is enabled in tagged mode, execValid = 1 with execTag = 1 makes bkptReq high in the next cycle. A marked opcode that never reaches execution (it is flushed) produces no request.
- R6: When the unit is enabled and the mode bit is 1 (forced), any valid access to the match address arms a pending request. This holds for a read, a write or a fetch. bkptReq is high in the cycle after the first instBoundary strobe in or after the cycle of the access, so a boundary in the same cycle as the access fires at once.
- R7: bkptReq is a single-cycle pulse. Issuing a forced request clears the pending flag, so a later boundary with no new hit gives no request.
- R8: Writing the enable bit to 0, or switching the mode bit to tagged, discards a pending forced request.
- R9: The compare covers all 16 address bits: an address that differs from the match address in only bit 0 or only bit 15 is not a hit.
- R10: In forced mode fetchTag stays low and execTag has no effect on bkptReq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select (0 match address, 1 control) |
| regWrData | input | 16 | Register write data |
| busAddr | input | 16 | CPU address bus |
| busValid | input | 1 | Bus access valid this cycle |
| busFetch | input | 1 | Current access is an opcode fetch |
| instBoundary | input | 1 | Instruction boundary strobe |
| execValid | input | 1 | An opcode leaves the queue for execution |
| execTag | input | 1 | Mark carried by the executing opcode |
| fetchTag | output | 1 | Mark to store with the fetched opcode |
| bkptReq | output | 1 | Request to enter background mode (one-cycle pulse) |

## Verification
In forced mode, the access that arms the breakpoint and the instruction-boundary strobe that releases it can fall in the same cycle. The bench provokes this with a fetch of the match address that has instBoundary asserted in the same cycle, and expects bkptReq on the very next cycle rather than at the following boundary. The opposite case is also checked: a boundary one cycle after the request must leave bkptReq low. A register write that disables the unit, or that changes its mode, while a request is pending is also driven between the access and the boundary. The check there is that the boundary produces nothing.

// File: rtl/addr_bkpt_pkg.sv
package addr_bkpt_pkg;

  localparam int ADDR_W    = 16;
  localparam int REG_AW    = 2;
  localparam int MATCH_IDX = 0;
  localparam int CTRL_IDX  = 1;
  localparam int EN_BIT    = 0;
  localparam int FORCE_BIT = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMatch;  // capture write data into the match register
    logic tagArm;     // tagging allowed this cycle
  } dpStrobe_t;

endpackage

// File: rtl/addr_bkpt_dp.sv
module addr_bkpt_dp
  import addr_bkpt_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic [AW-1:0] wrData,
  input  logic [AW-1:0] busAddr,
  input  logic          busValid,
  input  logic          busFetch,
  output logic          anyHit,
  output logic          fetchTag
);

  logic [AW-1:0] matchQ;
  logic [AW-1:0] diffBits;
  logic          addrEq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) matchQ <= '0;
    else if (strobe.loadMatch) matchQ <= wrData;
  end

  // bitwise difference, reduced below
  genvar gi;
  generate
    for (gi = 0; gi < AW; gi++) begin : g_cmp
      assign diffBits[gi] = busAddr[gi] ^ matchQ[gi];
    end
  endgenerate

  assign addrEq   = ~|diffBits;
  assign anyHit   = busValid && addrEq;
  assign fetchTag = strobe.tagArm && anyHit && busFetch;

  a_r2_match_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadMatch |=> (matchQ == $past(wrData)));

  a_r4_tag_needs_fetch: assert property (@(posedge clk) disable iff (!rstN)
    fetchTag |-> (busValid && busFetch));

endmodule

// File: rtl/addr_bkpt_ctl.sv
module addr_bkpt_ctl
  import addr_bkpt_pkg::*;
#(
  parameter int RAW = REG_AW
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWrEn,
  input  logic [RAW-1:0] regAddr,
  input  logic [1:0]     ctrlData,
  input  logic           anyHit,
  input  logic           instBoundary,
  input  logic           execValid,
  input  logic           execTag,
  output dpStrobe_t      strobe,
  output logic           bkptReq
);

  logic enableQ;
  logic forceSelQ;
  logic pendQ;
  logic reqQ;
  logic wrCtrl;
  logic forcedOn;
  logic taggedOn;
  logic forceHit;
  logic fireForce;
  logic fireTag;

  assign wrCtrl   = regWrEn && (regAddr == RAW'(CTRL_IDX));
  assign forcedOn = enableQ && forceSelQ;
  assign taggedOn = enableQ && !forceSelQ;

  assign strobe.loadMatch = regWrEn && (regAddr == RAW'(MATCH_IDX));
  assign strobe.tagArm    = taggedOn;

  assign forceHit  = forcedOn && anyHit;
  assign fireForce = forcedOn && instBoundary && (pendQ || forceHit);
  assign fireTag   = taggedOn && execValid && execTag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ   <= 1'b0;
      forceSelQ <= 1'b0;
    end else if (wrCtrl) begin
      enableQ   <= ctrlData[EN_BIT];
      forceSelQ <= ctrlData[FORCE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          pendQ <= 1'b0;
    else if (!forcedOn) pendQ <= 1'b0;
    else if (fireForce) pendQ <= 1'b0;
    else if (forceHit)  pendQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqQ <= 1'b0;
    else       reqQ <= fireForce || fireTag;
  end

  assign bkptReq = reqQ;

  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |=> !bkptReq);

  a_r8_pending_dropped: assert property (@(posedge clk) disable iff (!rstN)
    !(enableQ && forceSelQ) |=> !pendQ);

  a_r6_boundary_fires: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ && forceSelQ && pendQ && instBoundary) |=> (bkptReq && !pendQ));

  a_r5_tag_exec_fires: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ && !forceSelQ && execValid && execTag) |=> bkptReq);

  a_r10_no_tag_forced: assert property (@(posedge clk) disable iff (!rstN)
    (forceSelQ && !pendQ && !anyHit) |=> !bkptReq);

endmodule

// File: rtl/addr_bkpt.sv
module addr_bkpt
  import addr_bkpt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busValid,
  input  logic              busFetch,
  input  logic              instBoundary,
  input  logic              execValid,
  input  logic              execTag,
  output logic              fetchTag,
  output logic              bkptReq
);

  dpStrobe_t strobe;
  logic      anyHit;

  addr_bkpt_ctl #(.RAW(REG_AW)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .regWrEn      (regWrEn),
    .regAddr      (regAddr),
    .ctrlData     (regWrData[1:0]),
    .anyHit       (anyHit),
    .instBoundary (instBoundary),
    .execValid    (execValid),
    .execTag      (execTag),
    .strobe       (strobe),
    .bkptReq      (bkptReq)
  );

  addr_bkpt_dp #(.AW(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrData   (regWrData),
    .busAddr  (busAddr),
    .busValid (busValid),
    .busFetch (busFetch),
    .anyHit   (anyHit),
    .fetchTag (fetchTag)
  );

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (bkptReq && !instBoundary && !execValid) |=> !bkptReq);

endmodule

// File: tb/addr_bkpt_tb.sv
module addr_bkpt_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] busAddr = '0;
  logic        busValid = 1'b0;
  logic        busFetch = 1'b0;
  logic        instBoundary = 1'b0;
  logic        execValid = 1'b0;
  logic        execTag = 1'b0;
  logic        fetchTag;
  logic        bkptReq;

  int nChecks = 0;
  int nFails  = 0;
  logic tagSeen;
  logic reqSeen;

  always #(CLK_P/2) clk = ~clk;

  addr_bkpt u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .busAddr(busAddr), .busValid(busValid),
    .busFetch(busFetch), .instBoundary(instBoundary), .execValid(execValid),
    .execTag(execTag), .fetchTag(fetchTag), .bkptReq(bkptReq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one bus cycle: tag sampled before the edge, request after it
  task automatic cyc(input logic [15:0] a, input logic v, input logic f,
                     input logic b, input logic ev, input logic et);
    @(negedge clk);
    regWrEn = 1'b0;
    busAddr = a; busValid = v; busFetch = f;
    instBoundary = b; execValid = ev; execTag = et;
    #1 tagSeen = fetchTag;
    @(posedge clk);
    #1 reqSeen = bkptReq;
  endtask

  task automatic idle();
    cyc(16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    busValid = 1'b0; instBoundary = 1'b0; execValid = 1'b0; execTag = 1'b0;
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic tReset();
    #1;
    check("R1 fetchTag after reset", fetchTag, 1'b0);
    check("R1 bkptReq after reset", bkptReq, 1'b0);
    cyc(16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R1 disabled at reset, no tag at 0x0000", tagSeen, 1'b0);
    check("R1 disabled at reset, no request", reqSeen, 1'b0);
  endtask

  task automatic tDisabled();
    wrReg(2'd0, 16'h1234);
    wrReg(2'd1, 16'h0002);  // forced, disabled
    cyc(16'h1234, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R3 disabled forced hit", reqSeen, 1'b0);
    wrReg(2'd1, 16'h0000);  // tagged, disabled
    cyc(16'h1234, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R3 disabled tagged fetch", tagSeen, 1'b0);
    check("R3 disabled tagged exec", reqSeen, 1'b0);
  endtask

  task automatic tTagged();
    wrReg(2'd1, 16'h0001);  // enabled, tagged
    cyc(16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 tag on matching fetch", tagSeen, 1'b1);
    cyc(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4 no tag on data access", tagSeen, 1'b0);
    cyc(16'h1235, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R9 bit0 differs", tagSeen, 1'b0);
    cyc(16'h9234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R9 bit15 differs", tagSeen, 1'b0);
    cyc(16'h1234, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R5 boundary does not fire tagged mode", reqSeen, 1'b0);
    cyc(16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R5 marked opcode executes", reqSeen, 1'b1);
    idle();
    check("R7 tagged request is one pulse", reqSeen, 1'b0);
    cyc(16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4 second tag", tagSeen, 1'b1);
    cyc(16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R5 unmarked exec", reqSeen, 1'b0);
    for (int i = 0; i < 3; i++) begin
      idle();
      check("R5 flushed marked opcode", reqSeen, 1'b0);
    end
  endtask

  task automatic tForced();
    wrReg(2'd1, 16'h0003);  // enabled, forced
    cyc(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 read hit waits for boundary", reqSeen, 1'b0);
    idle();
    check("R6 still pending", reqSeen, 1'b0);
    cyc(16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R6 boundary fires pending", reqSeen, 1'b1);
    cyc(16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 pending cleared after request", reqSeen, 1'b0);
    cyc(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);  // write access
    cyc(16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R6 write hit fires at boundary", reqSeen, 1'b1);
    cyc(16'h1234, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R10 no tag in forced mode", tagSeen, 1'b0);
    check("R6 hit and boundary same cycle", reqSeen, 1'b1);
    idle();
    check("R7 one-cycle pulse", reqSeen, 1'b0);
    cyc(16'h0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R10 execTag ignored in forced mode", reqSeen, 1'b0);
    cyc(16'h1235, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R9 near miss in forced mode", reqSeen, 1'b0);
  endtask

  task automatic tClear();
    cyc(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    wrReg(2'd1, 16'h0002);  // disable
    wrReg(2'd1, 16'h0003);
    cyc(16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 disable drops pending", reqSeen, 1'b0);
    cyc(16'h1234, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    wrReg(2'd1, 16'h0001);  // to tagged
    wrReg(2'd1, 16'h0003);
    cyc(16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R8 mode switch drops pending", reqSeen, 1'b0);
  endtask

  task automatic tRegs();
    wrReg(2'd1, 16'h0001);
    wrReg(2'd2, 16'hABCD);
    wrReg(2'd3, 16'h0000);
    cyc(16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 writes to 2 and 3 ignored", tagSeen, 1'b1);
    wrReg(2'd0, 16'hFFFF);
    cyc(16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 new match address", tagSeen, 1'b1);
    cyc(16'h1234, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2 old match address gone", tagSeen, 1'b0);
  endtask

  initial begin
    #(CLK_P * 50000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_P * 2 + 2) rstN = 1'b1;
    tReset();
    tDisabled();
    tTagged();
    tForced();
    tClear();
    tRegs();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule